// File: doc/BRIEF.md
# Cascaded System Clock-Enable Divider Bank

This block turns one source tick stream into three synchronous clock-enable strobes: a core enable, a bus enable, and a peripheral enable. The core and bus strobes are divided down from the selected source. The peripheral strobe is divided down from the bus strobe, so its period is the product of the bus and peripheral divisors. A 32-bit clock-set word holds three small select codes and one source flag. The flag picks between a PLL tick and a crystal tick. The crystal reference is nominally 14.7456 MHz. Each select code indexes a fixed, irregular table of divisors, and the bus table includes the non-power-of-two divisors 5 and 6.

Everything runs in one clock domain (`clk`). Both sources arrive as single-cycle tick qualifiers in that domain. Each output enable is high for exactly one `clk` cycle, and only on a cycle where the selected source tick is high. A divisor of 1 passes every source tick straight through.

The configuration input is sampled continuously, but a new word only becomes active on a tick where all three enables fire together. This keeps a divisor change from cutting a period short. The active word resets to crystal source with every divisor 1, so every enable fires on the first source tick after reset. The control pins carry no handshake, and none is needed.

Top module: `sysclk_strobe_gen`

## Requirements
- R1: Bit 23 of the active word selects the source: 1 uses `pll_tick`, 0 uses `xtal_tick`.
- R2: The core select is bits 27:25. It maps codes 0..7 to divisors 1,2,4,8,16,1,1,1. The core enable fires once every divisor source ticks.
- R3: The bus select is bits 22:20. It maps codes 0..7 to divisors 1,2,4,5,6,8,16,32. The bus enable fires once every divisor source ticks.
- R4: The peripheral select is bits 19:18. It maps codes 0..3 to divisors 1,2,4,8. The divisor counts bus enables, not source ticks.
- R5: The peripheral enable is never high unless the bus enable is high in the same cycle.
- R6: While `rst_n` is low, all enables are low. The active word then resets to crystal source with all divisors 1, so the first crystal tick after reset raises all three enables together.
- R7: A new `cfg_word` becomes active only at the clock edge that ends a cycle in which all three enables are high. It governs the enables from the next source tick on. Until then the previous word keeps governing them.
- R8: Every enable is high only in a cycle where the selected source tick is high. Enables are single-cycle pulses whenever their divisor exceeds 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all logic and ticks are in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_tick | input | 1 | PLL source tick qualifier |
| xtal_tick | input | 1 | Crystal source tick qualifier |
| cfg_word | input | 32 | Clock-set word (source flag and three divisor selects) |
| core_en | output | 1 | Core clock-enable strobe |
| bus_en | output | 1 | Bus clock-enable strobe |
| per_en | output | 1 | Peripheral clock-enable strobe (cascaded from bus) |

## Verification
The bench measures the spacing of the enable pulses for every entry of all three tables, including the bus divisors 5 and 6. A design with a mis-entered table entry, such as treating code 3 as 4 or the core codes 5 to 7 as 32, produces the wrong spacing. It also measures peripheral spacing on top of a bus divisor of 5. That measurement exposes a peripheral divider that counts source ticks instead of bus pulses. The source flag is tested with a PLL tick every cycle and a crystal tick every fourth cycle, so a swapped select shows up as a fourfold spacing error. The deferral test changes the word right after a core pulse and expects fifteen silent cycles. A design that applied the word at once would fire early. The reset test checks that all enables stay quiet during reset and that all three fire together on the first cycle after it.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int CFG_W    = 32;
  localparam int CNT_W    = 5;   // holds divisor-1 up to 31
  localparam int SRC_BIT  = 23;  // 1: PLL tick, 0: crystal tick
  localparam int CORE_LSB = 25;
  localparam int CORE_W   = 3;
  localparam int BUS_LSB  = 20;
  localparam int BUS_W    = 3;
  localparam int PER_LSB  = 18;
  localparam int PER_W    = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic use_pll;
    cnt_t core_m1;
    cnt_t bus_m1;
    cnt_t per_m1;
  } clk_setting_t;
endpackage

// File: rtl/sysclk_cfg_decode.sv
module sysclk_cfg_decode
  import sysclk_pkg::*;
(
  input  logic [CFG_W-1:0] word,
  output clk_setting_t     setting
);
  logic [CORE_W-1:0] core_code;
  logic [BUS_W-1:0]  bus_code;
  logic [PER_W-1:0]  per_code;
  logic              unused_bits;

  assign core_code   = word[CORE_LSB +: CORE_W];
  assign bus_code    = word[BUS_LSB +: BUS_W];
  assign per_code    = word[PER_LSB +: PER_W];
  assign unused_bits = ^{word[CFG_W-1:CORE_LSB+CORE_W], word[SRC_BIT+1],
                         word[PER_LSB-1:0]};

  always_comb begin
    setting.use_pll = word[SRC_BIT];
    case (core_code)
      3'd1:    setting.core_m1 = cnt_t'(1);
      3'd2:    setting.core_m1 = cnt_t'(3);
      3'd3:    setting.core_m1 = cnt_t'(7);
      3'd4:    setting.core_m1 = cnt_t'(15);
      default: setting.core_m1 = cnt_t'(0);
    endcase
    case (bus_code)
      3'd1:    setting.bus_m1 = cnt_t'(1);
      3'd2:    setting.bus_m1 = cnt_t'(3);
      3'd3:    setting.bus_m1 = cnt_t'(4);
      3'd4:    setting.bus_m1 = cnt_t'(5);
      3'd5:    setting.bus_m1 = cnt_t'(7);
      3'd6:    setting.bus_m1 = cnt_t'(15);
      3'd7:    setting.bus_m1 = cnt_t'(31);
      default: setting.bus_m1 = cnt_t'(0);
    endcase
    case (per_code)
      2'd1:    setting.per_m1 = cnt_t'(1);
      2'd2:    setting.per_m1 = cnt_t'(3);
      2'd3:    setting.per_m1 = cnt_t'(7);
      default: setting.per_m1 = cnt_t'(0);
    endcase
  end
endmodule

// File: rtl/sysclk_strobe_div.sv
module sysclk_strobe_div #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cur_m1,
  input  logic [W-1:0] nxt_m1,
  input  logic         swap,
  output logic         strobe
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign strobe  = rst_n & tick & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (at_zero) cnt_q <= swap ? nxt_m1 : cur_m1;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sysclk_strobe_gen.sv
module sysclk_strobe_gen
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_tick,
  input  logic             xtal_tick,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             core_en,
  output logic             bus_en,
  output logic             per_en
);
  logic [CFG_W-1:0] act_q;
  clk_setting_t     cur_s;
  clk_setting_t     nxt_s;
  logic             src_tick;
  logic             swap;

  sysclk_cfg_decode u_cur_dec (.word(act_q),    .setting(cur_s));
  sysclk_cfg_decode u_nxt_dec (.word(cfg_word), .setting(nxt_s));

  assign src_tick = cur_s.use_pll ? pll_tick : xtal_tick;
  assign swap     = core_en & bus_en & per_en;

  sysclk_strobe_div #(.W(CNT_W)) u_core_div (
    .clk(clk), .rst_n(rst_n), .tick(src_tick),
    .cur_m1(cur_s.core_m1), .nxt_m1(nxt_s.core_m1),
    .swap(swap), .strobe(core_en)
  );

  sysclk_strobe_div #(.W(CNT_W)) u_bus_div (
    .clk(clk), .rst_n(rst_n), .tick(src_tick),
    .cur_m1(cur_s.bus_m1), .nxt_m1(nxt_s.bus_m1),
    .swap(swap), .strobe(bus_en)
  );

  // peripheral divider counts bus pulses, not source ticks
  sysclk_strobe_div #(.W(CNT_W)) u_per_div (
    .clk(clk), .rst_n(rst_n), .tick(bus_en),
    .cur_m1(cur_s.per_m1), .nxt_m1(nxt_s.per_m1),
    .swap(swap), .strobe(per_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= '0;
    else if (swap) act_q <= cfg_word;
  end
endmodule

// File: rtl/sysclk_strobe_gen_chk.sv
module sysclk_strobe_gen_chk
  import sysclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pll_tick,
  input logic             xtal_tick,
  input logic             core_en,
  input logic             bus_en,
  input logic             per_en,
  input logic [CFG_W-1:0] act
);
  logic sel_tick;
  assign sel_tick = act[SRC_BIT] ? pll_tick : xtal_tick;

  assert_core_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> sel_tick);
  assert_bus_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> sel_tick);
  assert_per_within_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> bus_en);
  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_en && bus_en && per_en) |=> $stable(act));
  assert_core_bypass_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tick && (act[CORE_LSB +: CORE_W] == 3'd0 || act[CORE_LSB +: CORE_W] >= 3'd5))
      |-> core_en);
  assert_bus_unity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tick && act[BUS_LSB +: BUS_W] == 3'd0) |-> bus_en);
  assert_source_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act[SRC_BIT] && !pll_tick) |-> !core_en && !bus_en);
endmodule

bind sysclk_strobe_gen sysclk_strobe_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
  .core_en(core_en), .bus_en(bus_en), .per_en(per_en), .act(act_q)
);

// File: tb/sysclk_strobe_gen_test.sv
`timescale 1ns/1ps
module sysclk_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pll_tick = 1'b1;
  logic        xtal_tick = 1'b1;
  logic [31:0] cfg_word = 32'h0;
  logic        core_en, bus_en, per_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int xper   = 1;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sysclk_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .cfg_word(cfg_word), .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
  );

  function automatic int core_div(int c);
    case (c) 1: return 2; 2: return 4; 3: return 8; 4: return 16; default: return 1; endcase
  endfunction
  function automatic int bus_div(int c);
    case (c) 1: return 2; 2: return 4; 3: return 5; 4: return 6;
             5: return 8; 6: return 16; 7: return 32; default: return 1; endcase
  endfunction
  function automatic int per_div(int c);
    case (c) 1: return 2; 2: return 4; 3: return 8; default: return 1; endcase
  endfunction
  function automatic logic [31:0] mk(int src, int c, int b, int p);
    // filler in unused fields must not matter
    return (32'(src) << 23) | (32'(c) << 25) | (32'(b) << 20) | (32'(p) << 18) | 32'h0000_5a5a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive ticks just after the falling edge, sample 1 ns later
  task automatic step();
    @(negedge clk);
    pll_tick  = 1'b1;
    xtal_tick = (cyc % xper) == 0;
    #1;
    cyc++;
  endtask

  task automatic measure(input string req, input logic [31:0] cw, input int ec,
                         input int eb, input int ep, input int tp, input int settle);
    int lc = -1, lb = -1, lp = -1, nc = 0, nb = 0, np = 0;
    int ci = ec * tp, bi = eb * tp, pi = eb * ep * tp;
    int win = 2 * ((ci > pi) ? ci : pi) + 4;
    cfg_word = cw;
    repeat (settle) step();
    for (int i = 0; i < win; i++) begin
      step();
      if (core_en) begin
        if (lc >= 0) chk(cyc - lc == ci, {req, " core spacing"}, cyc - lc, ci);
        lc = cyc; nc++;
      end
      if (bus_en) begin
        if (lb >= 0) chk(cyc - lb == bi, {req, " bus spacing"}, cyc - lb, bi);
        lb = cyc; nb++;
      end
      if (per_en) begin
        chk(bus_en == 1'b1, "R5 per without bus", 0, 1);
        if (lp >= 0) chk(cyc - lp == pi, {req, " per spacing"}, cyc - lp, pi);
        lp = cyc; np++;
      end
    end
    chk(nc >= 2, {req, " core pulses seen"}, nc, 2);
    chk(nb >= 2, {req, " bus pulses seen"}, nb, 2);
    chk(np >= 2, {req, " per pulses seen"}, np, 2);
  endtask

  task automatic test_reset();
    cfg_word = mk(0, 2, 0, 0);
    xper = 1;
    rst_n = 1'b0;
    repeat (3) begin
      step();
      chk({core_en, bus_en, per_en} == 3'b000, "R6 quiet in reset", {core_en, bus_en, per_en}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    cyc++;
    chk({core_en, bus_en, per_en} == 3'b111, "R6 first tick after reset", {core_en, bus_en, per_en}, 7);
    step();  // word now active: core divides by 4
    chk(core_en == 1'b0, "R7 word applied after common pulse", core_en, 0);
    chk(bus_en == 1'b1, "R6 bus div1 keeps firing", bus_en, 1);
  endtask

  task automatic test_core_table();  // R2
    xper = 1;
    for (int c = 0; c < 8; c++)
      measure($sformatf("R2 code %0d", c), mk(0, c, 0, 0), core_div(c), 1, 1, 1, 600);
  endtask

  task automatic test_bus_table();  // R3, includes divisors 5 and 6
    xper = 1;
    for (int b = 0; b < 8; b++)
      measure($sformatf("R3 code %0d", b), mk(0, 0, b, 0), 1, bus_div(b), 1, 1, 600);
  endtask

  task automatic test_per_table();  // R4, cascaded on bus divisor 5
    xper = 1;
    for (int p = 0; p < 4; p++)
      measure($sformatf("R4 code %0d", p), mk(0, 1, 3, p), 2, 5, per_div(p), 1, 600);
  endtask

  task automatic test_source();  // R1: PLL every cycle, crystal every 4th
    xper = 4;
    measure("R1 pll source", mk(1, 1, 1, 1), 2, 2, 2, 1, 1100);
    measure("R1 xtal source", mk(0, 1, 1, 1), 2, 2, 2, 4, 1100);
  endtask

  task automatic test_deferral();  // R7
    int guard = 0;
    xper = 1;
    cfg_word = mk(1, 4, 0, 0);
    repeat (600) step();
    do begin step(); guard++; end while (!core_en && guard < 40);
    chk(core_en == 1'b1, "R7 sync to core pulse", core_en, 1);
    @(posedge clk);
    #1 cfg_word = mk(1, 0, 0, 0);
    for (int j = 1; j <= 15; j++) begin
      step();
      chk(core_en == 1'b0, $sformatf("R7 old divisor held, cycle %0d", j), core_en, 0);
    end
    step();
    chk(core_en == 1'b1, "R7 terminal pulse on old divisor", core_en, 1);
    step();
    chk(core_en == 1'b1, "R7 new divisor active", core_en, 1);
    step();
    chk(core_en == 1'b1, "R8 div1 on every tick", core_en, 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    test_reset();
    test_core_table();
    test_bus_table();
    test_per_table();
    test_source();
    test_deferral();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end
endmodule